// File: doc/BRIEF.md
# Lane-Masked SIMD Branch Executor

An eight-lane integer SIMD datapath. A single instruction is broadcast to every lane each cycle, and an if/else region that depends on the data is run by masking lanes. When a run starts, the block captures a vector of signed elements and builds a per-lane condition bit that is set when the element is greater than zero. It then issues three short programs in a fixed order. The first is the taken program, with only the condition lanes enabled. The second is the not-taken program, with the complemented mask. The third is a tail program with every lane enabled, which models reconvergence. Lanes that are masked off still see the broadcast instruction, but their register is not written.

A program whose mask is empty, or whose length is zero, is passed over at no cost in cycles. Two counters record lane-cycles: the number of lanes enabled and the number of lanes issued. Utilization is the ratio of the two. At its worst it falls to one lane in eight.

Top module: `lane_mask_simd`

## Requirements
- R1: A start is taken only when the block is idle. It loads the vector from `vec_i`, where lane l occupies bits [32l+31:32l]. Condition bit l is 1 exactly when lane l, read as signed, is greater than zero.
- R2: The taken program runs first, one instruction per cycle. It writes only the lanes whose condition bit is 1, and every other lane keeps its value.
- R3: The not-taken program runs next, under the complemented condition. Lanes whose condition bit is 1 stay unchanged.
- R4: The tail program runs last, with all eight lanes enabled.
- R5: A program is skipped with zero cycles when its length is 0 or its mask has no set bit. The run takes exactly the sum of the lengths of the programs that execute.
- R6: `done_o` pulses for one cycle, one cycle after the last issued instruction, or one cycle after the start when nothing runs. `res_o` then holds until the next start.
- R7: Each 18-bit instruction carries the opcode in bits [17:16] and a signed 16-bit constant in bits [15:0]. Opcode 0 adds the constant, 1 multiplies by the constant (keeping the low 32 bits), 2 loads the constant and 3 leaves the lane unchanged. Slot i of a program lies at bits [18i+17:18i].
- R8: `active_o` and `total_o` clear at a start. Each issued cycle adds the number of enabled lanes to `active_o` and adds 8 to `total_o`.
- R9: A program length above MAX_OPS (4) is treated as MAX_OPS.
- R10: A start raised while the block is busy is ignored and does not disturb the run in progress.
- R11: `mask_o` shows the lane enable of the current issue cycle, and is zero when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (ignored while busy) |
| vec_i | input | 256 | Eight signed 32-bit elements |
| t_prog_i | input | 72 | Taken-path program, four slots |
| t_len_i | input | 3 | Taken-path length |
| f_prog_i | input | 72 | Not-taken-path program |
| f_len_i | input | 3 | Not-taken-path length |
| u_prog_i | input | 72 | Tail program, all lanes enabled |
| u_len_i | input | 3 | Tail length |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mask_o | output | 8 | Lane enable of the current cycle |
| res_o | output | 256 | Lane values |
| active_o | output | 16 | Enabled lane-cycles |
| total_o | output | 16 | Issued lane-cycles |

## Verification
The bench uses the default parameters: 8 lanes, 32-bit elements, 16-bit constants and MAX_OPS of 4. With those values the 3-bit length fields can hold lengths of 5 to 7, which is what makes the clamp reachable. The vector widths also allow an all-positive, an all-non-positive and a single-true-lane pattern. The single-true-lane pattern produces the one-in-eight utilization case. Four-slot programs are long enough to cover every opcode and to keep a run busy while a second start is presented.

// File: rtl/simd_branch_pkg.sv
`timescale 1ns/1ps
package simd_branch_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_MULK = 2'd1, OP_LDK = 2'd2, OP_PASS = 2'd3} op_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_TRUE = 2'd1, PH_FALSE = 2'd2, PH_TAIL = 2'd3} phase_e;

  // next non-empty phase after cur (PH_IDLE = just accepted)
  function automatic phase_e pick_phase(phase_e cur, logic t_ok, logic f_ok, logic u_ok);
    phase_e nxt;
    unique case (cur)
      PH_IDLE:  nxt = t_ok ? PH_TRUE : (f_ok ? PH_FALSE : (u_ok ? PH_TAIL : PH_IDLE));
      PH_TRUE:  nxt = f_ok ? PH_FALSE : (u_ok ? PH_TAIL : PH_IDLE);
      PH_FALSE: nxt = u_ok ? PH_TAIL : PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
  import simd_branch_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int IMM_W  = 16
) (
  input  op_e               op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ELEM_W-1:0] a_i,
  output logic [ELEM_W-1:0] y_o
);
  logic [ELEM_W-1:0] k;
  assign k = {{(ELEM_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + k;
      OP_MULK: y_o = a_i * k;
      OP_LDK:  y_o = k;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
  import simd_branch_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ELEM_W-1:0] init_i,
  input  logic              issue_i,
  input  logic              en_i,
  input  op_e               op_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ELEM_W-1:0] val_o
);
  logic [ELEM_W-1:0] val_q, alu_y;

  simd_lane_alu #(.ELEM_W(ELEM_W), .IMM_W(IMM_W)) u_alu (
    .op_i (op_i),
    .imm_i(imm_i),
    .a_i  (val_q),
    .y_o  (alu_y)
  );

  // masked lanes compute but never write back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                val_q <= '0;
    else if (load_i)            val_q <= init_i;
    else if (issue_i && en_i)   val_q <= alu_y;
  end

  assign val_o = val_q;

  a_r2_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !en_i && !load_i) |=> $stable(val_q));
endmodule

// File: rtl/simd_cond_mask.sv
`timescale 1ns/1ps
module simd_cond_mask #(
  parameter int NLANES = 8,
  parameter int ELEM_W = 32
) (
  input  logic [NLANES*ELEM_W-1:0] vec_i,
  output logic [NLANES-1:0]        mask_o
);
  for (genvar l = 0; l < NLANES; l++) begin : g_cmp
    assign mask_o[l] = $signed(vec_i[l*ELEM_W +: ELEM_W]) > 0;
  end
endmodule

// File: rtl/simd_util_counter.sv
`timescale 1ns/1ps
module simd_util_counter #(
  parameter int NLANES = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              issue_i,
  input  logic [NLANES-1:0] en_i,
  output logic [CNT_W-1:0]  active_o,
  output logic [CNT_W-1:0]  total_o
);
  logic [CNT_W-1:0] pop;

  always_comb begin
    pop = '0;
    for (int l = 0; l < NLANES; l++) pop = pop + CNT_W'(en_i[l]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      total_o  <= '0;
    end else if (clear_i) begin
      active_o <= '0;
      total_o  <= '0;
    end else if (issue_i) begin
      active_o <= active_o + pop;
      total_o  <= total_o + CNT_W'(NLANES);
    end
  end

  a_r8_active_le_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o <= total_o);
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i && !clear_i) |=> $stable(total_o));
endmodule

// File: rtl/simd_issue_ctrl.sv
`timescale 1ns/1ps
module simd_issue_ctrl
  import simd_branch_pkg::*;
#(
  parameter int NLANES  = 8,
  parameter int IMM_W   = 16,
  parameter int MAX_OPS = 4,
  localparam int INSTR_W = IMM_W + 2,
  localparam int PROG_W  = MAX_OPS * INSTR_W,
  localparam int LEN_W   = $clog2(MAX_OPS + 1),
  localparam int PC_W    = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NLANES-1:0] cond_i,
  input  logic [PROG_W-1:0] t_prog_i,
  input  logic [LEN_W-1:0]  t_len_i,
  input  logic [PROG_W-1:0] f_prog_i,
  input  logic [LEN_W-1:0]  f_len_i,
  input  logic [PROG_W-1:0] u_prog_i,
  input  logic [LEN_W-1:0]  u_len_i,
  output logic              load_o,
  output logic              issue_o,
  output logic [NLANES-1:0] en_o,
  output op_e               op_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              done_o
);
  function automatic logic [LEN_W-1:0] clamp(logic [LEN_W-1:0] len);
    return (len > LEN_W'(MAX_OPS)) ? LEN_W'(MAX_OPS) : len;
  endfunction

  phase_e             phase_q, nxt_phase;
  logic [PC_W-1:0]    pc_q;
  logic [NLANES-1:0]  cm_q, src_cm;
  logic [PROG_W-1:0]  tp_q, fp_q, up_q, cur_prog;
  logic [LEN_W-1:0]   tl_q, fl_q, ul_q, src_tl, src_fl, src_ul, cur_len;
  logic               accept, last, t_ok, f_ok, u_ok, done_q;
  logic [INSTR_W-1:0] slot;

  assign accept = start_i && (phase_q == PH_IDLE);
  assign issue_o = (phase_q != PH_IDLE);
  assign load_o  = accept;

  // path flags come from the inputs in the accept cycle, latched copies after
  assign src_cm = accept ? cond_i : cm_q;
  assign src_tl = accept ? clamp(t_len_i) : tl_q;
  assign src_fl = accept ? clamp(f_len_i) : fl_q;
  assign src_ul = accept ? clamp(u_len_i) : ul_q;
  assign t_ok   = (|src_cm) && (src_tl != '0);
  assign f_ok   = (|(~src_cm)) && (src_fl != '0);
  assign u_ok   = (src_ul != '0);

  always_comb begin
    unique case (phase_q)
      PH_TRUE:  begin cur_prog = tp_q; cur_len = tl_q; en_o = cm_q;  end
      PH_FALSE: begin cur_prog = fp_q; cur_len = fl_q; en_o = ~cm_q; end
      PH_TAIL:  begin cur_prog = up_q; cur_len = ul_q; en_o = '1;    end
      default:  begin cur_prog = '0;   cur_len = '0;   en_o = '0;    end
    endcase
  end

  assign slot  = cur_prog[pc_q*INSTR_W +: INSTR_W];
  assign op_o  = op_e'(slot[IMM_W +: 2]);
  assign imm_o = slot[IMM_W-1:0];
  assign last  = issue_o && ((LEN_W'(pc_q) + LEN_W'(1)) == cur_len);
  assign nxt_phase = pick_phase(accept ? PH_IDLE : phase_q, t_ok, f_ok, u_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pc_q    <= '0;
      cm_q    <= '0;
      tp_q    <= '0;
      fp_q    <= '0;
      up_q    <= '0;
      tl_q    <= '0;
      fl_q    <= '0;
      ul_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cm_q    <= cond_i;
        tp_q    <= t_prog_i;
        fp_q    <= f_prog_i;
        up_q    <= u_prog_i;
        tl_q    <= src_tl;
        fl_q    <= src_fl;
        ul_q    <= src_ul;
        pc_q    <= '0;
        phase_q <= nxt_phase;
        done_q  <= (nxt_phase == PH_IDLE);
      end else if (last) begin
        pc_q    <= '0;
        phase_q <= nxt_phase;
        done_q  <= (nxt_phase == PH_IDLE);
      end else if (issue_o) begin
        pc_q    <= pc_q + PC_W'(1);
      end
    end
  end

  assign done_o = done_q;

  a_r5_no_empty_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (en_o != '0));
  a_r3_false_after_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FALSE) |=> (phase_q != PH_TRUE));
  a_r4_tail_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TAIL) |=> (phase_q == PH_TAIL || phase_q == PH_IDLE));
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE));
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && start_i) |=> $stable(cm_q));
endmodule

// File: rtl/lane_mask_simd.sv
`timescale 1ns/1ps
module lane_mask_simd
  import simd_branch_pkg::*;
#(
  parameter int NLANES  = 8,
  parameter int ELEM_W  = 32,
  parameter int IMM_W   = 16,
  parameter int MAX_OPS = 4,
  parameter int CNT_W   = 16,
  localparam int INSTR_W = IMM_W + 2,
  localparam int PROG_W  = MAX_OPS * INSTR_W,
  localparam int LEN_W   = $clog2(MAX_OPS + 1),
  localparam int VEC_W   = NLANES * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PROG_W-1:0] t_prog_i,
  input  logic [LEN_W-1:0]  t_len_i,
  input  logic [PROG_W-1:0] f_prog_i,
  input  logic [LEN_W-1:0]  f_len_i,
  input  logic [PROG_W-1:0] u_prog_i,
  input  logic [LEN_W-1:0]  u_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NLANES-1:0] mask_o,
  output logic [VEC_W-1:0]  res_o,
  output logic [CNT_W-1:0]  active_o,
  output logic [CNT_W-1:0]  total_o
);
  logic [NLANES-1:0] cond, en;
  logic              load, issue;
  op_e               op;
  logic [IMM_W-1:0]  imm;

  simd_cond_mask #(.NLANES(NLANES), .ELEM_W(ELEM_W)) u_cond (
    .vec_i (vec_i),
    .mask_o(cond)
  );

  simd_issue_ctrl #(.NLANES(NLANES), .IMM_W(IMM_W), .MAX_OPS(MAX_OPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cond_i  (cond),
    .t_prog_i(t_prog_i),
    .t_len_i (t_len_i),
    .f_prog_i(f_prog_i),
    .f_len_i (f_len_i),
    .u_prog_i(u_prog_i),
    .u_len_i (u_len_i),
    .load_o  (load),
    .issue_o (issue),
    .en_o    (en),
    .op_o    (op),
    .imm_o   (imm),
    .done_o  (done_o)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    simd_lane #(.ELEM_W(ELEM_W), .IMM_W(IMM_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .init_i (vec_i[l*ELEM_W +: ELEM_W]),
      .issue_i(issue),
      .en_i   (en[l]),
      .op_i   (op),
      .imm_i  (imm),
      .val_o  (res_o[l*ELEM_W +: ELEM_W])
    );
  end

  simd_util_counter #(.NLANES(NLANES), .CNT_W(CNT_W)) u_util (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .issue_i (issue),
    .en_i    (en),
    .active_o(active_o),
    .total_o (total_o)
  );

  assign busy_o = issue;
  assign mask_o = en;

  a_r11_idle_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mask_o == '0));
endmodule

// File: tb/lane_mask_simd_bench.sv
`timescale 1ns/1ps
module lane_mask_simd_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] vec = '0;
  logic [71:0]  tp = '0, fp = '0, up = '0;
  logic [2:0]   tl = '0, fl = '0, ul = '0;
  logic         busy, done;
  logic [7:0]   mask;
  logic [255:0] res;
  logic [15:0]  act, tot;
  int           n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lane_mask_simd u_lane_mask_simd (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vec_i(vec),
    .t_prog_i(tp), .t_len_i(tl), .f_prog_i(fp), .f_len_i(fl),
    .u_prog_i(up), .u_len_i(ul), .busy_o(busy), .done_o(done),
    .mask_o(mask), .res_o(res), .active_o(act), .total_o(tot)
  );

  task automatic chk(input bit ok, input string what, input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, a, e);
    end
  endtask

  function automatic logic [17:0] ins(input logic [1:0] op, input int imm);
    return {op, imm[15:0]};
  endfunction

  function automatic logic [71:0] prog(input logic [17:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  function automatic logic [255:0] pack(input int v[8]);
    logic [255:0] r;
    for (int l = 0; l < 8; l++) r[l*32 +: 32] = v[l];
    return r;
  endfunction

  function automatic logic [31:0] apply(input logic [31:0] a, input logic [17:0] i);
    logic [31:0] k;
    k = {{16{i[15]}}, i[15:0]};
    case (i[17:16])
      2'd0:    return a + k;
      2'd1:    return a * k;
      2'd2:    return k;
      default: return a;
    endcase
  endfunction

  // requirement-level reference model
  task automatic model(input logic [255:0] v, input logic [71:0] p0, p1, p2,
                       input logic [2:0] l0, l1, l2,
                       output logic [255:0] r, output int cyc, output int ac, output int tt);
    logic [7:0]  cm, en;
    logic [71:0] pr;
    int          ln;
    r = v; cyc = 0; ac = 0; tt = 0;
    for (int l = 0; l < 8; l++) cm[l] = ($signed(v[l*32 +: 32]) > 0);
    for (int ph = 0; ph < 3; ph++) begin
      en = (ph == 0) ? cm : (ph == 1) ? ~cm : 8'hff;
      pr = (ph == 0) ? p0 : (ph == 1) ? p1 : p2;
      ln = (ph == 0) ? int'(l0) : (ph == 1) ? int'(l1) : int'(l2);
      if (ln > 4) ln = 4;
      if (en == 8'h00) ln = 0;
      for (int s = 0; s < ln; s++) begin
        for (int l = 0; l < 8; l++)
          if (en[l]) r[l*32 +: 32] = apply(r[l*32 +: 32], pr[s*18 +: 18]);
        cyc++; ac += $countones(en); tt += 8;
      end
    end
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      cyc++;
      if (cyc > 100) begin
        chk(0, "R5 run never finished", cyc, 0);
        break;
      end
    end
  endtask

  task automatic run_case(input string tag, input logic [255:0] v,
                          input logic [71:0] p0, p1, p2, input logic [2:0] l0, l1, l2);
    logic [255:0] er;
    int ec, ea, et, cyc;
    model(v, p0, p1, p2, l0, l1, l2, er, ec, ea, et);
    vec = v; tp = p0; fp = p1; up = p2; tl = l0; fl = l1; ul = l2;
    kick();
    wait_done(cyc);
    for (int l = 0; l < 8; l++)
      chk(res[l*32 +: 32] == er[l*32 +: 32], $sformatf("%s lane%0d", tag, l),
          res[l*32 +: 32], er[l*32 +: 32]);
    chk(cyc == ec, {tag, " R5 cycles"}, cyc, ec);
    chk(int'(act) == ea, {tag, " R8 active"}, act, ea);
    chk(int'(tot) == et, {tag, " R8 total"}, tot, et);
    chk(!busy, {tag, " R6 idle after done"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(res == '0, "reset res", res[31:0], 0);
    chk(!busy && !done, "reset R6 busy/done", {busy, done}, 0);
    chk(mask == 8'h00, "reset R11 mask", mask, 0);
    chk(act == 0 && tot == 0, "reset R8 counters", tot, 0);
  endtask

  task automatic t_mixed();
    run_case("R1 R2 R3 R4 R7 mixed", pack('{5, -3, 0, 7, -1, 2, -8, 1}),
             prog(ins(0, 10), ins(1, 3), 18'h0, 18'h0),
             prog(ins(2, -4), 18'h0, 18'h0, 18'h0),
             prog(ins(0, 1), 18'h0, 18'h0, 18'h0), 3'd2, 3'd1, 3'd1);
  endtask

  task automatic t_all_pos();
    run_case("R5 false path skipped", pack('{1, 2, 3, 4, 5, 6, 7, 100}),
             prog(ins(0, -1), ins(0, 2), 18'h0, 18'h0),
             prog(ins(2, 9), ins(2, 9), 18'h0, 18'h0),
             prog(ins(1, 2), 18'h0, 18'h0, 18'h0), 3'd2, 3'd2, 3'd1);
  endtask

  task automatic t_all_nonpos();
    run_case("R1 R5 true path skipped", pack('{0, -1, 32'h8000_0000, -5, 0, -2, -3, -4}),
             prog(ins(2, 77), ins(2, 77), 18'h0, 18'h0),
             prog(ins(1, -2), ins(0, 3), ins(3, 0), 18'h0),
             18'h0, 3'd2, 3'd3, 3'd0);
  endtask

  task automatic t_worst();
    run_case("R8 one lane active", pack('{-1, -1, -1, 9, -1, -1, -1, -1}),
             prog(ins(0, 1), ins(0, 1), ins(1, 5), 18'h0),
             '0, '0, 3'd3, 3'd0, 3'd0);
  endtask

  task automatic t_empty();
    run_case("R6 empty run", pack('{3, -3, 4, -4, 5, -5, 6, -6}),
             prog(ins(2, 1), 18'h0, 18'h0, 18'h0),
             prog(ins(2, 1), 18'h0, 18'h0, 18'h0),
             '0, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic t_clamp();
    run_case("R9 R7 length clamp", pack('{2, 3, -7, 11, 1, -9, 4, 6}),
             prog(ins(1, -3), ins(3, 0), ins(0, 100), ins(1, 2)),
             prog(ins(0, -1), 18'h0, 18'h0, 18'h0),
             '0, 3'd7, 3'd1, 3'd0);
  endtask

  task automatic t_busy();
    logic [255:0] er, hold;
    int ec, ea, et, cyc;
    logic [71:0] p;
    p = prog(ins(0, 1), ins(0, 1), ins(0, 1), ins(0, 1));
    model(pack('{1, 2, 3, 4, 5, 6, 7, 8}), p, '0, '0, 3'd4, 3'd0, 3'd0, er, ec, ea, et);
    vec = pack('{1, 2, 3, 4, 5, 6, 7, 8}); tp = p; fp = '0; up = '0;
    tl = 3'd4; fl = '0; ul = '0;
    kick();
    vec = pack('{-9, -9, -9, -9, -9, -9, -9, -9}); tl = 3'd1;
    start = 1'b1;
    @(negedge clk); @(negedge clk);
    start = 1'b0;
    cyc = 2;
    forever begin
      @(negedge clk);
      if (done || cyc > 50) break;
      cyc++;
    end
    chk(cyc == ec, "R10 run length kept", cyc, ec);
    chk(res == er, "R10 start while busy ignored", res[31:0], er[31:0]);
    hold = res;
    repeat (3) @(negedge clk);
    chk(res == hold && !done, "R6 result held after done", res[31:0], hold[31:0]);
  endtask

  task automatic t_mask();
    logic [255:0] v;
    v = pack('{5, -3, 0, 7, -1, 2, -8, 1});
    vec = v; tp = prog(ins(0, 1), ins(0, 1), 18'h0, 18'h0);
    fp = prog(ins(0, 2), 18'h0, 18'h0, 18'h0); up = prog(ins(0, 3), 18'h0, 18'h0, 18'h0);
    tl = 3'd2; fl = 3'd1; ul = 3'd1;
    kick();
    @(negedge clk);
    chk(mask == 8'b1010_1001 && busy, "R11 taken mask c1", mask, 8'b1010_1001);
    @(negedge clk);
    chk(mask == 8'b1010_1001, "R11 taken mask c2", mask, 8'b1010_1001);
    @(negedge clk);
    chk(mask == 8'b0101_0110, "R11 R3 complement mask", mask, 8'b0101_0110);
    @(negedge clk);
    chk(mask == 8'hff, "R11 R4 tail full mask", mask, 8'hff);
    @(negedge clk);
    chk(done && mask == 8'h00, "R11 R6 idle mask with done", {done, mask}, 9'h100);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mixed();
    t_all_pos();
    t_all_nonpos();
    t_worst();
    t_empty();
    t_clamp();
    t_busy();
    t_mask();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule